// File: doc/BRIEF.md
# Dual-Bank Interrupt Aggregation Controller

This block collects sixty-four interrupt request lines and reduces them to a single interrupt output for one CPU. The lines are split into two banks of 32 bits each. Every bank keeps a sticky event word that records rising edges, an enable mask that software writes, a live copy of the input levels, and a fixed per-bit flag, set at build time, that marks a source as level-sensitive. Level-sensitive sources never latch an event. They raise the interrupt only while their input is high and enabled. All other sources latch an event that stays set until software acknowledges it.

Each raw input goes through a synchronizer before it is used. Software reaches the banks through a 32-bit register port that takes one request per cycle and has no back-pressure: a request is accepted in the cycle its valid is high. Read data comes back one cycle later with a response valid pulse. The CPU interrupt is a combinational function of the registered bank state. Its low-order source numbers map to the higher bank, so source `s` lands in bank `1 - s/32`, bit `s mod 32`.

Top module: `irq_agg_ctrl`

## Requirements
- R1: After reset, the event, mask and level words of both banks read zero, `cpu_irq` is low and `rsp_valid` is low.
- R2: Source `s` is mapped to bank `1 - s/32`, bit `s mod 32`. The level word bit of that source is 1 while the synchronized input is high and 0 while it is low.
- R3: A rising edge on a source that is not level-sensitive sets its event bit. A later falling edge leaves the event bit set.
- R4: A level-sensitive source never sets its event bit. With default parameters, bank 1 bits 20 to 28 are level-sensitive, which covers sources 20 to 28. No bit in bank 0 is level-sensitive.
- R5: A write to the acknowledge word (offset 0x8) clears the event bits where the write data is 1 and leaves the bits where it is 0.
- R6: If an acknowledge clears a bit in the same cycle that a new rising edge arrives for it, the bit stays set.
- R7: The mask word (offset 0x4) reads back what was written. A bank is pending when `(events | (levels & level_sensitive)) & mask` is nonzero, and `cpu_irq` is high when either bank is pending.
- R8: The bank is chosen by address bits [11:4]: value 1 selects bank 0 (0x010 to 0x01F) and value 2 selects bank 1 (0x020 to 0x02F). Within a bank, offset 0x0 reads events, 0x4 reads the mask, 0xC reads levels, and the acknowledge offset 0x8 reads zero. Any other offset, or any other bank value, reads zero and ignores writes. A write to offset 0x0 or 0xC is also ignored.
- R9: A read request produces `rsp_valid` high and the addressed word on `rsp_rdata` one cycle later. `rsp_valid` is low in cycles that do not follow a read.
- R10: An enabled level-sensitive source drives `cpu_irq` high while its input is high. `cpu_irq` drops once the input is low, without any acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_irq | input | 64 | Raw interrupt request lines, source 0 in bit 0 |
| req_valid | input | 1 | Register request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte address of the register |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read |
| rsp_rdata | output | 32 | Read data |
| cpu_irq | output | 1 | Interrupt request to the CPU |

## Verification
The bench builds the block with its default parameters: 32-bit banks, a two-stage synchronizer, a 12-bit address, and level-sensitive bits 20 to 28 in bank 1 only. At this size it is practical to sweep every one of the 64 sources through raise, mask, lower and acknowledge. It is also practical to read every byte address of the low 64-byte window plus addresses whose bank field is out of range. These sweeps reach both banks, the reversed numbering, and the border between edge and level-sensitive bits. The acknowledge-versus-new-edge collision is driven in the exact cycle the edge is latched.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  // word selected inside a bank by address bits [3:2]
  typedef enum logic [1:0] {
    REG_EVENT = 2'd0,
    REG_MASK  = 2'd1,
    REG_ACK   = 2'd2,
    REG_LEVEL = 2'd3
  } reg_kind_e;

  localparam int NUM_BANKS = 2;
endpackage

// File: rtl/irq_agg_decode.sv
module irq_agg_decode
  import irq_agg_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int BANK_CNT  = 2
) (
  input  logic [ADDR_W-1:0]   addr,
  output logic [BANK_CNT-1:0] bank_hit,
  output reg_kind_e           kind,
  output logic                word_ok
);
  localparam int IDX_W = ADDR_W - 4;

  // bank field value 1 selects bank 0, value 2 selects bank 1, and so on
  for (genvar b = 0; b < BANK_CNT; b++) begin : g_hit
    assign bank_hit[b] = (addr[ADDR_W-1:4] == IDX_W'(b + 1));
  end

  assign kind    = reg_kind_e'(addr[3:2]);
  assign word_ok = (addr[1:0] == 2'b00);
endmodule

// File: rtl/irq_agg_sync.sv
module irq_agg_sync #(
  parameter int W      = 64,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw,
  output logic [W-1:0] lvl,
  output logic [W-1:0] rise
);
  logic [STAGES-1:0][W-1:0] chain;
  logic [W-1:0]             prev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chain <= '0;
      prev  <= '0;
    end else begin
      chain[0] <= raw;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
      prev <= chain[STAGES-1];
    end
  end

  assign lvl  = chain[STAGES-1];
  assign rise = chain[STAGES-1] & ~prev;
endmodule

// File: rtl/irq_agg_bank.sv
module irq_agg_bank #(
  parameter int           W     = 32,
  parameter logic [W-1:0] LSENS = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  input  logic [W-1:0] rise,
  input  logic         ack_we,
  input  logic         mask_we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] ev_q,
  output logic [W-1:0] mask_q,
  output logic         pending
);
  logic [W-1:0] clr_bits;
  logic [W-1:0] set_bits;

  // level-sensitive bits are neither cleared nor set in the event word
  assign clr_bits = ack_we ? (wdata & ~LSENS) : '0;
  assign set_bits = rise & ~LSENS;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ev_q   <= '0;
      mask_q <= '0;
    end else begin
      // set after clear: a fresh edge beats a simultaneous acknowledge
      ev_q <= (ev_q & ~clr_bits) | set_bits;
      if (mask_we) mask_q <= wdata;
    end
  end

  assign pending = |((ev_q | (lvl & LSENS)) & mask_q);
endmodule

// File: rtl/irq_agg_ctrl.sv
module irq_agg_ctrl
  import irq_agg_pkg::*;
#(
  parameter int                BANK_W      = 32,
  parameter int                SYNC_STAGES = 2,
  parameter int                ADDR_W      = 12,
  parameter logic [BANK_W-1:0] LSENS_B0    = '0,
  parameter logic [BANK_W-1:0] LSENS_B1    = BANK_W'(32'h1FF0_0000)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_BANKS*BANK_W-1:0]   src_irq,
  input  logic                          req_valid,
  input  logic                          req_write,
  input  logic [ADDR_W-1:0]             req_addr,
  input  logic [BANK_W-1:0]             req_wdata,
  output logic                          rsp_valid,
  output logic [BANK_W-1:0]             rsp_rdata,
  output logic                          cpu_irq
);
  localparam int NUM_SRC = NUM_BANKS * BANK_W;

  logic [NUM_SRC-1:0]                 src_lvl;
  logic [NUM_SRC-1:0]                 src_rise;
  logic [NUM_BANKS-1:0][BANK_W-1:0]   bank_ev;
  logic [NUM_BANKS-1:0][BANK_W-1:0]   bank_mask;
  logic [NUM_BANKS-1:0][BANK_W-1:0]   bank_lvl;
  logic [NUM_BANKS-1:0]               bank_pend;
  logic [NUM_BANKS-1:0]               bank_hit;
  reg_kind_e                          kind;
  logic                               word_ok;
  logic [BANK_W-1:0]                  rd_word;
  logic                               rd_req;
  logic                               wr_req;

  irq_agg_sync #(.W(NUM_SRC), .STAGES(SYNC_STAGES)) sync_i (
    .clk  (clk),
    .rst_n(rst_n),
    .raw  (src_irq),
    .lvl  (src_lvl),
    .rise (src_rise)
  );

  irq_agg_decode #(.ADDR_W(ADDR_W), .BANK_CNT(NUM_BANKS)) dec_i (
    .addr    (req_addr),
    .bank_hit(bank_hit),
    .kind    (kind),
    .word_ok (word_ok)
  );

  assign rd_req = req_valid & ~req_write;
  assign wr_req = req_valid &  req_write;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    // reversed numbering: the lowest sources feed the highest bank
    localparam int SRC_BASE = (NUM_BANKS - 1 - b) * BANK_W;
    localparam logic [BANK_W-1:0] LS = (b == 0) ? LSENS_B0 : LSENS_B1;
    logic sel_ok;
    assign sel_ok      = wr_req & bank_hit[b] & word_ok;
    assign bank_lvl[b] = src_lvl[SRC_BASE +: BANK_W];

    irq_agg_bank #(.W(BANK_W), .LSENS(LS)) bank_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .lvl    (src_lvl[SRC_BASE +: BANK_W]),
      .rise   (src_rise[SRC_BASE +: BANK_W]),
      .ack_we (sel_ok & (kind == REG_ACK)),
      .mask_we(sel_ok & (kind == REG_MASK)),
      .wdata  (req_wdata),
      .ev_q   (bank_ev[b]),
      .mask_q (bank_mask[b]),
      .pending(bank_pend[b])
    );
  end

  always_comb begin
    rd_word = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (bank_hit[b] && word_ok) begin
        unique case (kind)
          REG_EVENT: rd_word = bank_ev[b];
          REG_MASK:  rd_word = bank_mask[b];
          REG_LEVEL: rd_word = bank_lvl[b];
          default:   rd_word = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_req;
      if (rd_req) rsp_rdata <= rd_word;
    end
  end

  assign cpu_irq = |bank_pend;
endmodule

// File: rtl/irq_agg_ctrl_chk.sv
module irq_agg_ctrl_chk #(
  parameter int           W      = 32,
  parameter int           ADDR_W = 12,
  parameter logic [W-1:0] LS0    = '0,
  parameter logic [W-1:0] LS1    = '0
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  req_valid,
  input logic                  req_write,
  input logic [ADDR_W-1:0]     req_addr,
  input logic [W-1:0]          req_wdata,
  input logic                  rsp_valid,
  input logic                  cpu_irq,
  input logic [1:0][W-1:0]     ev,
  input logic [1:0][W-1:0]     mask
);
  logic bank_field_bad;
  assign bank_field_bad = (req_addr[ADDR_W-1:4] != (ADDR_W-4)'(1)) &&
                          (req_addr[ADDR_W-1:4] != (ADDR_W-4)'(2));

  p_rsp_follows_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid);

  p_rsp_needs_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid && !req_write));

  p_lsens_no_event_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((ev[0] & LS0) | (ev[1] & LS1)) == '0);

  p_irq_needs_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq |-> ((mask[0] | mask[1]) != '0));

  p_events_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_write) |=> ((ev & $past(ev)) == $past(ev)));

  p_mask_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_addr == ADDR_W'(12'h014)) |=> (mask[0] == $past(req_wdata)));

  p_stray_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && bank_field_bad) |=> $stable(mask));
endmodule

bind irq_agg_ctrl irq_agg_ctrl_chk #(
  .W(BANK_W), .ADDR_W(ADDR_W), .LS0(LSENS_B0), .LS1(LSENS_B1)
) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_valid(req_valid),
  .req_write(req_write),
  .req_addr (req_addr),
  .req_wdata(req_wdata),
  .rsp_valid(rsp_valid),
  .cpu_irq  (cpu_irq),
  .ev       (bank_ev),
  .mask     (bank_mask)
);

// File: tb/irq_agg_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_agg_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [63:0] src_irq;
  logic        req_valid;
  logic        req_write;
  logic [11:0] req_addr;
  logic [31:0] req_wdata;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        cpu_irq;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  irq_agg_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .src_irq(src_irq),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .cpu_irq(cpu_irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // called at a negedge, returns at a negedge
  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    chk("R9 rsp_valid after read", {31'd0, rsp_valid}, 32'd1);
    d = rsp_rdata;
  endtask

  function automatic bit is_lsens(input int s);
    return (s >= 20 && s <= 28);
  endfunction

  // expected read value for the decode sweep
  function automatic logic [31:0] dec_exp(input logic [11:0] a,
      input logic [31:0] e0, m0, l0, e1, m1, l1);
    logic [31:0] ev, mk, lv;
    if (a[11:4] == 8'd1) begin ev = e0; mk = m0; lv = l0; end
    else if (a[11:4] == 8'd2) begin ev = e1; mk = m1; lv = l1; end
    else return 32'd0;
    case (a[3:0])
      4'h0: return ev;
      4'h4: return mk;
      4'hC: return lv;
      default: return 32'd0;
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    rst_n = 1'b0; src_irq = '0; req_valid = 1'b0; req_write = 1'b0;
    req_addr = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 cpu_irq", {31'd0, cpu_irq}, 32'd0);
    chk("R1 rsp_valid", {31'd0, rsp_valid}, 32'd0);
    foreach (d[i]) ;
    for (int a = 'h10; a < 'h30; a += 4) begin
      rd(12'(a), d);
      chk($sformatf("R1 word at %h", a), d, 32'd0);
    end
    idle(1);
    chk("R9 rsp_valid idle", {31'd0, rsp_valid}, 32'd0);

    // sweep of every source: R2 R3 R4 R5 R7 R10
    for (int s = 0; s < 64; s++) begin
      logic [11:0] base;
      logic [31:0] bitv;
      base = (s < 32) ? 12'h020 : 12'h010;
      bitv = 32'd1 << (s % 32);
      src_irq[s] = 1'b1;
      idle(4);
      rd(base + 12'hC, d);
      chk($sformatf("R2 level src %0d high", s), d, bitv);
      rd(base, d);
      chk($sformatf("R3/R4 event src %0d", s), d, is_lsens(s) ? 32'd0 : bitv);
      chk($sformatf("R7 masked irq src %0d", s), {31'd0, cpu_irq}, 32'd0);
      wr(base + 12'h4, bitv);
      rd(base + 12'h4, d);
      chk($sformatf("R7 mask readback src %0d", s), d, bitv);
      chk($sformatf("R7 enabled irq src %0d", s), {31'd0, cpu_irq}, 32'd1);
      src_irq[s] = 1'b0;
      idle(4);
      rd(base + 12'hC, d);
      chk($sformatf("R2 level src %0d low", s), d, 32'd0);
      rd(base, d);
      chk($sformatf("R3 sticky src %0d", s), d, is_lsens(s) ? 32'd0 : bitv);
      chk($sformatf("R10 irq after fall src %0d", s), {31'd0, cpu_irq},
          is_lsens(s) ? 32'd0 : 32'd1);
      wr(base + 12'h8, 32'hFFFF_FFFF);
      rd(base, d);
      chk($sformatf("R5 ack clears src %0d", s), d, 32'd0);
      chk($sformatf("R5 irq after ack src %0d", s), {31'd0, cpu_irq}, 32'd0);
      wr(base + 12'h4, 32'd0);
    end

    // R5 partial acknowledge and acknowledge to the other bank
    src_irq[0] = 1'b1; src_irq[3] = 1'b1; idle(4);
    src_irq[0] = 1'b0; src_irq[3] = 1'b0; idle(4);
    wr(12'h028, 32'hFFFF_FFF6);
    rd(12'h020, d);
    chk("R5 zero data bits kept", d, 32'h0000_0009);
    wr(12'h018, 32'hFFFF_FFFF);
    rd(12'h020, d);
    chk("R5 other bank ack no effect", d, 32'h0000_0009);
    wr(12'h028, 32'h0000_0008);
    rd(12'h020, d);
    chk("R5 single bit cleared", d, 32'h0000_0001);

    // R6 collision: bit 0 already set, re-raise and acknowledge in the latch cycle
    src_irq[0] = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    wr(12'h028, 32'h0000_0001);
    rd(12'h020, d);
    chk("R6 new edge beats ack", d, 32'h0000_0001);
    src_irq[0] = 1'b0; idle(4);
    wr(12'h028, 32'h0000_0001);
    rd(12'h020, d);
    chk("R6 later ack clears", d, 32'h0000_0000);

    // R8 decode sweep
    wr(12'h014, 32'hA5A5_5A5A);
    wr(12'h024, 32'h0F0F_F0F0);
    src_irq[32] = 1'b1; src_irq[1] = 1'b1; src_irq[20] = 1'b1;
    idle(5);
    for (int a = 0; a < 'h40; a++) begin
      rd(12'(a), d);
      chk($sformatf("R8 read addr %h", a), d,
          dec_exp(12'(a), 32'h1, 32'hA5A5_5A5A, 32'h1,
                  32'h2, 32'h0F0F_F0F0, 32'h0010_0002));
    end
    begin
      logic [11:0] far [4] = '{12'h110, 12'h210, 12'hFF4, 12'h120};
      foreach (far[i]) begin
        rd(far[i], d);
        chk($sformatf("R8 far read %h", far[i]), d, 32'd0);
      end
    end
    begin
      logic [11:0] junk [10] = '{12'h004, 12'h034, 12'h114, 12'h015, 12'h010,
                                 12'h01C, 12'h02C, 12'h026, 12'h008, 12'h038};
      foreach (junk[i]) wr(junk[i], 32'hFFFF_FFFF);
    end
    rd(12'h014, d); chk("R8 bank0 mask untouched", d, 32'hA5A5_5A5A);
    rd(12'h024, d); chk("R8 bank1 mask untouched", d, 32'h0F0F_F0F0);
    rd(12'h010, d); chk("R8 bank0 events untouched", d, 32'h1);
    rd(12'h020, d); chk("R8 bank1 events untouched", d, 32'h2);

    // R10 level source drives irq alone
    wr(12'h018, 32'hFFFF_FFFF);
    wr(12'h028, 32'hFFFF_FFFF);
    wr(12'h014, 32'd0);
    wr(12'h024, 32'h0010_0000);
    chk("R10 level high irq", {31'd0, cpu_irq}, 32'd1);
    src_irq[20] = 1'b0; idle(3);
    chk("R10 level low irq", {31'd0, cpu_irq}, 32'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule